// File: doc/BRIEF.md
# Clock-Recovery Lock and Loss-of-Signal Supervisor

This block decides, for a clock-recovery loop, whether the loop should follow the incoming serial data or fall back to the local reference clock. It runs entirely in the reference clock domain. The recovered clock reaches it as a per-reference-cycle count of recovered edges that has already been synchronized into that domain. The block sums that count over a fixed window of reference cycles and compares the sum with the nominal value. A mismatch beyond a tolerance of roughly 500 ppm means the frequency has drifted.

After reset the loop is held on the reference for a settle period. The block then hands the loop to the data and waits for two consecutive clean windows before it reports lock. Two conditions raise loss of signal: a missing signal-detect input, or a low on the active-low force-to-reference input. While loss of signal is raised, the receive data word is forced to zero. The loop-select output also tells downstream logic to take its clock from the reference-derived source, so a clock keeps running throughout.

Top module: `cdr_lock_supervisor`

## Requirements
- R1: During and right after a synchronous reset, `lock` is 0, `los` is 1, `trk_data` is 0 and `rx_data_out` is all zeros.
- R2: `los` is 1 whenever the synchronized `sig_det_in` is 0 or the synchronized `force_ref_n_in` is 0. Each input passes through two flops, so a change on either input shows on `los` after the second rising edge.
- R3: While `los` is 1, `rx_data_out` is zero. Otherwise it equals `rx_data_in`.
- R4: In the reference state, once `los` has been 0 for `SETTLE_CYC` consecutive edges (the counter starts from the first edge with `los` low), `trk_data` rises to 1 on that edge (1 = follow data, 0 = follow reference).
- R5: A window is 2^`WIN_LOG2` reference cycles, aligned to the release of reset. It sums `rec_edges` over the window. The window is in tolerance when |sum − `RATIO`·2^`WIN_LOG2`| ≤ `TOL`. Only a window spent entirely in data tracking is judged.
- R6: While acquiring data, two consecutive in-tolerance windows raise `lock`. Lock takes effect on the edge that ends the second window.
- R7: An out-of-tolerance window, whether the block is acquiring or locked, returns the loop to the reference: `trk_data` and `lock` fall on the window's last edge.
- R8: `los` rising while data is tracked returns the loop to the reference on the next edge. This takes priority over an in-tolerance window ending on that same edge.
- R9: The reference state is not left while `los` is 1, however long `los` stays high. The settle count restarts whenever `los` is 1.
- R10: `lock` is 1 only in the locked-to-data state, so `lock` implies `trk_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_det_in | input | 1 | Signal detect from the receiver, asynchronous |
| force_ref_n_in | input | 1 | Active-low request to force the loop onto the reference, asynchronous |
| rec_edges | input | EDGE_W | Recovered-clock edges counted in this reference cycle |
| rx_data_in | input | DATA_W | Recovered receive data |
| trk_data | output | 1 | Loop select: 1 follows data, 0 follows the reference (downstream clock is reference-derived) |
| lock | output | 1 | Locked to the incoming data |
| los | output | 1 | Loss of signal |
| rx_data_out | output | DATA_W | Receive data, muted to zero during loss of signal |

## Verification
Two events can fall on the same edge: the end of an in-tolerance window while locked, and the arrival of loss of signal through the synchronizers. The bench drops signal detect three cycles before a window closes, so that `los` first reaches the state logic on that window's last edge. It then expects the reference to win: `lock` and `trk_data` are low after that edge, and the data is already muted one cycle earlier while `lock` is still high. The table of windows walks the tolerance boundary in both directions, ±TOL and ±(TOL+1). It also checks that a partial window after re-entry is not counted toward lock.

// File: rtl/cdr_lock_supervisor.sv
module cdr_lock_supervisor #(
  parameter int WIN_LOG2   = 16,
  parameter int EDGE_W     = 2,
  parameter int RATIO      = 1,
  parameter int TOL        = 33,
  parameter int SETTLE_CYC = 1024,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_det_in,
  input  logic              force_ref_n_in,
  input  logic [EDGE_W-1:0] rec_edges,
  input  logic [DATA_W-1:0] rx_data_in,
  output logic              trk_data,
  output logic              lock,
  output logic              los,
  output logic [DATA_W-1:0] rx_data_out
);

  localparam int ACC_W = WIN_LOG2 + EDGE_W + 1;
  localparam int SET_W = $clog2(SETTLE_CYC) + 1;
  localparam logic [ACC_W-1:0] NOM = ACC_W'(RATIO) << WIN_LOG2;

  typedef enum logic [1:0] {ST_REF, ST_ACQ, ST_LCK} st_t;

  st_t               st, st_n;
  logic [1:0]        sd_q, fr_q;
  logic [WIN_LOG2-1:0] win_cnt;
  logic [ACC_W-1:0]  acc, total, diff;
  logic [SET_W-1:0]  settle_cnt;
  logic              armed, good, in_tol, win_end, eval;

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_q <= '0;
      fr_q <= '0;
    end else begin
      sd_q <= {sd_q[0], sig_det_in};
      fr_q <= {fr_q[0], force_ref_n_in};
    end
  end

  assign los         = ~(sd_q[1] & fr_q[1]);
  assign rx_data_out = los ? '0 : rx_data_in;

  assign win_end = &win_cnt;
  assign total   = acc + ACC_W'(rec_edges);
  assign diff    = (total >= NOM) ? total - NOM : NOM - total;
  assign in_tol  = diff <= ACC_W'(TOL);
  assign eval    = win_end & armed;

  always_comb begin
    st_n = st;
    case (st)
      ST_REF: if (!los && settle_cnt == SET_W'(SETTLE_CYC - 1)) st_n = ST_ACQ;
      ST_ACQ: if (los || (eval && !in_tol)) st_n = ST_REF;
              else if (eval && good) st_n = ST_LCK;
      ST_LCK: if (los || (eval && !in_tol)) st_n = ST_REF;
      default: st_n = ST_REF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_REF;
      win_cnt    <= '0;
      acc        <= '0;
      armed      <= 1'b0;
      good       <= 1'b0;
      settle_cnt <= '0;
    end else begin
      st      <= st_n;
      win_cnt <= win_cnt + 1'b1;
      acc     <= win_end ? '0 : total;

      if (st_n == ST_REF)  armed <= 1'b0;
      else if (win_end)    armed <= 1'b1;

      if (st_n != ST_ACQ)  good <= 1'b0;
      else if (eval)       good <= in_tol;

      if (st_n != ST_REF || los) settle_cnt <= '0;
      else                       settle_cnt <= settle_cnt + 1'b1;
    end
  end

  assign trk_data = (st != ST_REF);
  assign lock     = (st == ST_LCK);

  AST_LOCK_IMPLIES_TRACK: assert property (@(posedge clk) disable iff (rst)
    lock |-> trk_data);                                                  // R10
  AST_LOS_DROPS_TRACK: assert property (@(posedge clk) disable iff (rst)
    (los && trk_data) |=> !trk_data);                                    // R8
  AST_REF_HELD_IN_LOS: assert property (@(posedge clk) disable iff (rst)
    (!trk_data && los) |=> !trk_data);                                   // R9
  AST_BAD_WINDOW_EXITS: assert property (@(posedge clk) disable iff (rst)
    (eval && !in_tol) |=> (!trk_data && !lock));                         // R7
  AST_LOCK_AT_WINDOW_END: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(win_end));                                     // R6

endmodule

// File: tb/cdr_lock_supervisor_tb_top.sv
module cdr_lock_supervisor_tb_top;
  localparam int WL = 5;
  localparam int NW = 1 << WL;
  localparam int NV = 12;
  localparam int DELTA [NV] = '{0, 2, -2, 0, 3, 0, 1, -3, 0, 0, 2, -2};
  localparam logic [1:0] EXP [NV] = '{2'b01, 2'b01, 2'b11, 2'b11, 2'b00, 2'b01,
                                      2'b01, 2'b00, 2'b01, 2'b01, 2'b11, 2'b11};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sd = 1'b1, frn = 1'b1;
  logic [1:0] rec = 2'd1;
  logic [7:0] din = 8'hA5;
  logic       trk, lck, los;
  logic [7:0] dout;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cdr_lock_supervisor #(.WIN_LOG2(WL), .EDGE_W(2), .RATIO(1), .TOL(2),
                        .SETTLE_CYC(10), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .sig_det_in(sd), .force_ref_n_in(frn),
    .rec_edges(rec), .rx_data_in(din), .trk_data(trk), .lock(lck),
    .los(los), .rx_data_out(dout));

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_win(input int d, input int drop_at);
    for (int c = 0; c < NW; c++) begin
      if (d > 0 && c < d)       rec = 2'd2;
      else if (d < 0 && c < -d) rec = 2'd0;
      else                      rec = 2'd1;
      if (c == drop_at) sd = 1'b0;
      tick();
      if (drop_at >= 0 && c == drop_at) chk("R2 los before sync", los, 0);
      if (drop_at >= 0 && c == drop_at + 1) begin
        chk("R2 los after two flops", los, 1);
        chk("R3 mute on los", dout, 0);
        chk("R8 lock still high before edge", lck, 1);
      end
    end
  endtask

  initial begin
    repeat (4) tick();
    chk("R1 reset lock", lck, 0);
    chk("R1 reset los", los, 1);
    chk("R1 reset trk_data", trk, 0);
    chk("R1 reset data", dout, 0);
    rst = 1'b0;
    for (int w = 0; w < NV; w++) begin
      run_win(DELTA[w], -1);
      chk($sformatf("R5 R6 R7 window %0d lock", w), lck, EXP[w][1]);
      chk($sformatf("R4 R5 R7 window %0d trk_data", w), trk, EXP[w][0]);
    end
    chk("R3 data passes", dout, 8'hA5);
    run_win(0, NW - 3);
    chk("R8 los wins over good window lock", lck, 0);
    chk("R8 los wins over good window trk", trk, 0);
    chk("R10 lock implies trk", lck & ~trk, 0);
    repeat (40) tick();
    chk("R9 held on reference during los", trk, 0);
    chk("R3 still muted", dout, 0);
    sd = 1'b1; frn = 1'b0;
    repeat (5) tick();
    chk("R2 force low keeps los", los, 1);
    chk("R9 still on reference", trk, 0);
    frn = 1'b1;
    tick();
    chk("R2 los one edge after release", los, 1);
    tick();
    chk("R2 los clear after two edges", los, 0);
    chk("R3 data restored", dout, 8'hA5);
    repeat (9) tick();
    chk("R4 settle not yet done", trk, 0);
    tick();
    chk("R4 settle done", trk, 1);
    chk("R6 no lock without windows", lck, 0);
    rst = 1'b1;
    tick();
    chk("R1 mid-run reset trk", trk, 0);
    chk("R1 mid-run reset los", los, 1);
    chk("R1 mid-run reset lock", lck, 0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule